// File: doc/BRIEF.md
# Early-Resolving Branch Slice

This block is a multi-cycle processor slice that runs every instruction through five steps and carries out a branch-if-equal instruction. The equality test and the program counter update happen in the decode step (step 2), not one step later. To allow this, the slice places a dedicated equality comparator and a dedicated target adder beside the register file read ports. The adder forms the branch target from the incremented PC and the sign-extended, scaled offset while the register file is being read. A taken branch therefore writes the PC at the end of step 2, and steps 3 to 5 are idle for branches.

The slice contains the PC, the instruction register, two operand latches, and a two-port register file whose contents are preset: entry i holds floor(i/2). A synchronous instruction memory sits outside the slice and is addressed by the PC. A step indicator shows the current phase. Any opcode other than the branch passes through the five steps and leaves the PC at its incremented value.

Top module: `early_branch_slice`

## Requirements
- R1: While reset is active, the PC is 0 and the step indicator reads 1. After reset, the step advances 1, 2, 3, 4, 5 and then returns to 1, one step per clock.
- R2: `imem_addr` always shows the PC. At the end of step 1, the word on `imem_rdata` is loaded into the instruction register and the PC increases by 4.
- R3: At the end of step 2, `op_a` takes the register named by instruction bits 25:21 and `op_b` takes the register named by bits 20:16. Register i reads as floor(i/2), so register 0 reads as zero.
- R4: When the opcode (bits 31:26) equals 6'b000100 and the two registers read in step 2 are equal, the PC at the end of step 2 becomes the incremented PC plus the sign-extended bits 15:0 shifted left by 2.
- R5: When the opcode is not 6'b000100, or the two registers differ, the PC keeps its step-1 value through step 2.
- R6: The PC does not change at the end of steps 3, 4 or 5.
- R7: Negative offsets (bit 15 set) move the PC backward with two's-complement wrap. This includes an offset of -1, which branches back to the branch itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Instruction memory byte address (the PC) |
| imem_rdata | input | 32 | Word returned for the address captured at the previous rising edge |
| step | output | 3 | Current step, 1 to 5 |
| op_a | output | 32 | Operand latch for the first source register |
| op_b | output | 32 | Operand latch for the second source register |

## Verification
The assertions assume that the instruction memory returns, in step 1, the word for the PC captured at the previous edge, and that reset is held across at least one rising edge. The PC is stable from step 2 onward, so the bench memory model captures the next instruction word at every edge and changes that word only during steps 3 to 5 of the previous instruction. This keeps each fetch consistent with the PC the bench expects. Register fields in the stimulus always name one of the 32 preset entries, which holds by construction with 5-bit fields.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;
   localparam int RSEL_W = 5;
   localparam int IMM_W  = 16;

   typedef struct packed {
      logic [OPC_W-1:0]  opc;
      logic [RSEL_W-1:0] src_a;
      logic [RSEL_W-1:0] src_b;
      logic [IMM_W-1:0]  imm;
   } insn_t;

   localparam logic [OPC_W-1:0] OPC_BEQ_DEFAULT = 6'b000100;
endpackage

// File: rtl/ebr_step_seq.sv
module ebr_step_seq #(
   parameter int N_STEPS = 5,
   parameter int SW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [SW-1:0] step
);
   localparam logic [SW-1:0] FIRST = SW'(1);
   localparam logic [SW-1:0] LAST  = SW'(N_STEPS);

   if (N_STEPS < 3 || N_STEPS >= (1 << SW)) begin : g_bad_steps
      $error("ebr_step_seq: N_STEPS must be at least 3 and fit in SW bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            step <= FIRST;
      else if (step == LAST) step <= FIRST;
      else                   step <= step + SW'(1);
   end

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step == LAST) |=> (step == FIRST));                        // R1
   AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (step >= FIRST) && (step <= LAST));                          // R1
endmodule

// File: rtl/ebr_regfile.sv
module ebr_regfile #(
   parameter int DW     = 32,
   parameter int N_REGS = 32,
   parameter int N_RD   = 2,
   localparam int IW    = $clog2(N_REGS)
) (
   input  logic [N_RD-1:0][IW-1:0] rd_idx,
   output logic [N_RD-1:0][DW-1:0] rd_val
);
   logic [DW-1:0] cells [N_REGS];

   if (N_REGS < 2 || N_REGS > 32) begin : g_bad_regs
      $error("ebr_regfile: N_REGS must lie in 2..32");
   end

   for (genvar i = 0; i < N_REGS; i++) begin : g_cell
      if (i == 0) begin : g_zero
         assign cells[i] = '0;
      end else begin : g_preset
         assign cells[i] = DW'(i / 2);
      end
   end

   for (genvar p = 0; p < N_RD; p++) begin : g_port
      assign rd_val[p] = cells[rd_idx[p]];
      always_comb begin
         if (rd_idx[p] == '0)
            AST_ZERO_REG: assert (rd_val[p] == '0);                 // R3
      end
   end
endmodule

// File: rtl/ebr_target_add.sv
module ebr_target_add #(
   parameter int AW        = 32,
   parameter int IMM_W     = 16,
   parameter int OFF_SHIFT = 2
) (
   input  logic [AW-1:0]    pc_inc,
   input  logic [IMM_W-1:0] imm,
   output logic [AW-1:0]    target
);
   logic [AW-1:0] sx;

   if (AW < IMM_W + OFF_SHIFT) begin : g_bad_width
      $error("ebr_target_add: AW too narrow for scaled offset");
   end

   assign sx = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};

   if (OFF_SHIFT == 0) begin : g_byte
      assign target = pc_inc + sx;
   end else begin : g_scaled
      assign target = pc_inc + (sx << OFF_SHIFT);
   end
endmodule

// File: rtl/ebr_eq_cmp.sv
module ebr_eq_cmp #(
   parameter int DW      = 32,
   parameter bit XOR_RED = 1'b1
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          eq
);
   if (XOR_RED) begin : g_xor
      assign eq = ~|(a ^ b);
   end else begin : g_direct
      assign eq = (a == b);
   end
endmodule

// File: rtl/early_branch_slice.sv
module early_branch_slice #(
   parameter int AW               = 32,
   parameter int DW               = 32,
   parameter int N_REGS           = 32,
   parameter int N_STEPS          = 5,
   parameter int OFF_SHIFT        = 2,
   parameter logic [5:0] OPC_BEQ  = ebr_pkg::OPC_BEQ_DEFAULT
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] imem_addr,
   input  logic [31:0]   imem_rdata,
   output logic [2:0]    step,
   output logic [DW-1:0] op_a,
   output logic [DW-1:0] op_b
);
   import ebr_pkg::*;

   localparam int RIW = $clog2(N_REGS);
   localparam logic [2:0] S_FETCH  = 3'd1;
   localparam logic [2:0] S_DECODE = 3'd2;
   localparam logic [AW-1:0] INC = AW'(4);

   if (RIW > RSEL_W) begin : g_bad_sel
      $error("early_branch_slice: register count exceeds select field");
   end
   if (AW < 8) begin : g_bad_aw
      $error("early_branch_slice: AW too small");
   end

   logic [AW-1:0] pc, pc_nxt, target;
   insn_t         ir;
   logic          eq, is_beq, pc_we;
   logic [1:0][RIW-1:0] sel;
   logic [1:0][DW-1:0]  rdv;

   ebr_step_seq #(.N_STEPS(N_STEPS), .SW(3)) u_seq (
      .clk(clk), .rst_n(rst_n), .step(step)
   );

   assign sel[0] = ir.src_a[RIW-1:0];
   assign sel[1] = ir.src_b[RIW-1:0];

   ebr_regfile #(.DW(DW), .N_REGS(N_REGS), .N_RD(2)) u_rf (
      .rd_idx(sel), .rd_val(rdv)
   );

   ebr_eq_cmp #(.DW(DW), .XOR_RED(1'b1)) u_cmp (
      .a(rdv[0]), .b(rdv[1]), .eq(eq)
   );

   ebr_target_add #(.AW(AW), .IMM_W(IMM_W), .OFF_SHIFT(OFF_SHIFT)) u_tgt (
      .pc_inc(pc), .imm(ir.imm), .target(target)
   );

   assign is_beq    = (ir.opc == OPC_BEQ);
   assign imem_addr = pc;

   always_comb begin
      pc_we  = 1'b0;
      pc_nxt = pc;
      if (step == S_FETCH) begin
         pc_we  = 1'b1;
         pc_nxt = pc + INC;
      end else if (step == S_DECODE && is_beq && eq) begin
         pc_we  = 1'b1;
         pc_nxt = target;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= '0;
         ir <= '0;
      end else begin
         if (pc_we)           pc <= pc_nxt;
         if (step == S_FETCH) ir <= imem_rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_a <= '0;
         op_b <= '0;
      end else if (step == S_DECODE) begin
         op_a <= rdv[0];
         op_b <= rdv[1];
      end
   end

   AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_FETCH) |=> (pc == $past(pc) + INC));              // R2
   AST_TAKEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_DECODE && is_beq && rdv[0] == rdv[1]) |=> (pc == $past(target))); // R4
   AST_UNTAKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step == S_DECODE && !(is_beq && rdv[0] == rdv[1])) |=> $stable(pc)); // R5
   AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step > S_DECODE) |=> $stable(pc));                          // R6
endmodule

// File: tb/tb_early_branch_slice.sv
module tb_early_branch_slice;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, op_a, op_b;
   logic [2:0]  step;
   logic [31:0] next_word = 32'h0;
   logic [31:0] pc_exp = 32'h0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   always_ff @(posedge clk) imem_rdata <= next_word;

   early_branch_slice dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .step(step), .op_a(op_a), .op_b(op_b)
   );

   function automatic logic [31:0] mk(input logic [5:0] o, input int a, input int b,
                                      input logic [15:0] im);
      return {o, 5'(a), 5'(b), im};
   endfunction

   localparam int NV = 10;
   localparam logic [31:0] PROG [NV] = '{
      {6'd4, 5'd2,  5'd3,  16'd3},      // taken, forward
      {6'd4, 5'd2,  5'd4,  16'd5},      // 1 vs 2, not taken
      {6'd4, 5'd0,  5'd1,  16'hFFFE},   // zero operands, backward
      {6'd35,5'd2,  5'd3,  16'd7},      // non-branch, equal regs
      {6'd4, 5'd6,  5'd7,  16'hFFFA},   // backward to 0
      {6'd4, 5'd5,  5'd4,  16'd1},      // 2 == 2
      {6'd4, 5'd31, 5'd30, 16'h8000},   // most negative offset
      {6'd4, 5'd9,  5'd10, 16'hFFFF},   // 4 vs 5, not taken
      {6'd4, 5'd0,  5'd0,  16'hFFFF},   // branch to itself
      {6'd0, 5'd1,  5'd8,  16'h1234}    // other opcode
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Entered at a falling edge in step 1; leaves at the falling edge of the next step 1.
   task automatic run_one(input logic [31:0] ins, input logic [31:0] nxt);
      logic [31:0] va, vb, nw;
      logic        tk;
      string       rq;
      va = 32'(ins[25:21] >> 1);
      vb = 32'(ins[20:16] >> 1);
      tk = (ins[31:26] == 6'd4) && (va == vb);
      nw = tk ? pc_exp + 32'd4 + ({{16{ins[15]}}, ins[15:0]} << 2) : pc_exp + 32'd4;
      rq = !tk ? "R5" : (ins[15] ? "R7" : "R4");
      chk(step == 3'd1, "R1", 32'(step), 32'd1);
      chk(imem_addr == pc_exp, "R2", imem_addr, pc_exp);
      @(negedge clk);
      chk(step == 3'd2, "R1", 32'(step), 32'd2);
      chk(imem_addr == pc_exp + 32'd4, "R2", imem_addr, pc_exp + 32'd4);
      @(negedge clk);
      chk(imem_addr == nw, rq, imem_addr, nw);
      chk(op_a == va, "R3", op_a, va);
      chk(op_b == vb, "R3", op_b, vb);
      next_word = nxt;
      @(negedge clk);
      chk(imem_addr == nw, "R6", imem_addr, nw);
      @(negedge clk);
      chk(imem_addr == nw, "R6", imem_addr, nw);
      chk(step == 3'd5, "R1", 32'(step), 32'd5);
      @(negedge clk);
      pc_exp = nw;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      next_word = PROG[0];
      repeat (3) @(negedge clk);
      chk(imem_addr == 32'd0, "R1", imem_addr, 32'd0);
      chk(step == 3'd1, "R1", 32'(step), 32'd1);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         run_one(PROG[i], (i + 1 < NV) ? PROG[i+1] : 32'h0);
      end
      // reset in the middle of an instruction
      next_word = mk(6'd4, 2, 3, 16'd3);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(imem_addr == 32'd0, "R1", imem_addr, 32'd0);
      chk(step == 3'd1, "R1", 32'(step), 32'd1);
      rst_n = 1'b1;
      pc_exp = 32'd0;
      run_one(mk(6'd4, 2, 3, 16'd3), mk(6'd4, 0, 1, 16'hFFFF));
      run_one(mk(6'd4, 0, 1, 16'hFFFF), 32'h0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule